// File: doc/BRIEF.md
# Instruction Prefetch Unit

This block is the instruction-fetch master of a small pipelined processor. It keeps its own fetch address counter, which is separate from the program counter that software sees. It issues word reads back to back on a pipelined read bus. That bus has variable latency and a wait-request input. Returned instructions are handed to the decode stage together with the address they were fetched from, through a valid/stall handshake.

Decode can stall while reads are still outstanding, so returned words are parked in a small buffer whose depth is a parameter. New reads are issued only while the count of outstanding reads plus parked words stays within that depth. When the buffer is empty and decode is ready, a returning word goes straight to decode in the cycle it arrives.

Taken branches resolve a few stages later. When one is reported, the unit empties the buffer and reloads its fetch counter with the target address. It also drops as many future responses as it had reads outstanding, so no word fetched before the redirect ever reaches decode.

Top module: `instr_prefetch`

## Requirements
- R1: While reset is low, `bus_read` and `dec_valid` are 0. The first read after reset is issued at address `START_ADDR`.
- R2: A read is accepted on a clock edge where `bus_read` is 1 and `bus_waitreq` is 0. Without a redirect, each accepted read is followed by a read at an address 4 higher.
- R3: While `bus_read` is 1 and `bus_waitreq` is 1, the next cycle keeps `bus_read` at 1 and `bus_addr` unchanged.
- R4: The number of accepted reads whose data is still awaited and valid, plus the number of buffered instructions, never exceeds `DEPTH`. If decode stalls from reset and there are no bus waits, exactly `DEPTH` reads are issued.
- R5: Instructions reach decode in fetch order, each with its fetch address in `dec_addr`. While `dec_stall` is 1 and no branch is reported, `dec_valid`, `dec_instr` and `dec_addr` hold their values.
- R6: If the buffer is empty and `dec_stall` is 0, a valid response is shown on `dec_valid`/`dec_instr` in the same cycle as `bus_rvalid`.
- R7: After a taken branch, the next new read goes to `br_target` with bits [1:0] forced to 0. Responses to reads issued before the branch are discarded. The first instruction delivered afterwards is the one at the target.
- R8: `dec_valid` is 0 in every cycle where `br_taken` is 1.
- R9: If a branch arrives while a read is held by `bus_waitreq`, that read completes at its original address. The read after it goes to the branch target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | output | 32 | Byte address of the word read |
| bus_read | output | 1 | Read request strobe |
| bus_waitreq | input | 1 | Bus not ready; request must be held |
| bus_rdata | input | 32 | Returned instruction word |
| bus_rvalid | input | 1 | `bus_rdata` carries a response this cycle |
| br_taken | input | 1 | Taken branch reported by a later stage |
| br_target | input | 32 | Branch target byte address |
| dec_valid | output | 1 | Instruction offered to decode |
| dec_instr | output | 32 | Instruction word |
| dec_addr | output | 32 | Fetch address of `dec_instr` |
| dec_stall | input | 1 | Decode cannot take an instruction |

## Verification
A wrong fetch counter shows up on `bus_addr` at the very next accepted read. A wrong return-address counter shows up on `dec_addr` at the next delivered word. A discard counter that is too small lets a stale word through: the first delivery after a redirect then has an address other than the target, a few cycles after the branch. If the credit count is off, the read count during a long decode stall differs from the buffer depth, or the buffer overflows and words arrive out of order. The bench drives random bus waits, latencies, stalls and branches, and compares every accepted address and every delivered word against a model of the program flow.

// File: rtl/pf_pkg.sv
// Shared widths and types for the instruction prefetch unit.
// Assumes byte addressing of 32-bit instruction words.
package pf_pkg;
    localparam int unsigned PF_AW = 32;
    localparam int unsigned PF_DW = 32;

    // One buffered instruction together with its fetch address.
    typedef struct packed {
        logic [PF_AW-1:0] addr;
        logic [PF_DW-1:0] instr;
    } pf_entry_t;

    // Force a byte address onto a word boundary.
    function automatic logic [PF_AW-1:0] pf_align(input logic [PF_AW-1:0] a);
        return {a[PF_AW-1:2], 2'b00};
    endfunction
endpackage

// File: rtl/pf_fifo.sv
// Instruction buffer: a circular queue of DEPTH entries with synchronous
// flush. Assumes the caller never pushes when full or pops when empty,
// and never pushes in a flush cycle.
module pf_fifo
    import pf_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic                           push,
    input  pf_entry_t                      wr_data,
    input  logic                           pop,
    output pf_entry_t                      head,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    pf_entry_t        mem [DEPTH];
    logic [PW-1:0]    wp;
    logic [PW-1:0]    rp;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_data;
    end

    // Pointer and occupancy update, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= step_ptr(wp);
            if (pop)  rp <= step_ptr(rp);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rp];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));  // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));  // R5
endmodule

// File: rtl/pf_bus_ctl.sv
// Read-bus side of the prefetch unit: fetch address counter, request
// strobe, credit limit, redirect handling and stale-response discard.
// Assumes in-order responses, one per accepted read.
module pf_bus_ctl
    import pf_pkg::*;
#(
    parameter int unsigned DEPTH      = 4,
    parameter logic [31:0] START_ADDR = 32'h0000_0100
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_waitreq,
    input  logic                        bus_rvalid,
    input  logic                        br_taken,
    input  logic [PF_AW-1:0]            br_target,
    input  logic [$clog2(DEPTH+1)-1:0]  buf_cnt_nxt,
    output logic [PF_AW-1:0]            bus_addr,
    output logic                        bus_read,
    output logic                        flush,
    output logic                        stale,
    output logic                        apply,
    output logic [PF_AW-1:0]            apply_addr
);
    localparam int unsigned OUT_MAX = 2 * DEPTH;
    localparam int unsigned OW      = $clog2(OUT_MAX + 1);

    logic [PF_AW-1:0] ppc;
    logic             req_q;
    logic             redir_q;
    logic [PF_AW-1:0] tgt_q;
    logic [OW-1:0]    outst, outst_n;
    logic [OW-1:0]    discard, discard_n;
    logic [OW-1:0]    good_n;
    logic [OW:0]      credit_sum;
    logic             stuck, acc, room;

    // Bus handshake decode and redirect timing.
    always_comb begin
        stuck      = req_q & bus_waitreq;
        acc        = req_q & ~bus_waitreq;
        flush      = br_taken | redir_q;
        apply      = flush & ~stuck;
        apply_addr = pf_align(br_taken ? br_target : tgt_q);
        stale      = flush | (discard != '0);
    end

    // Next outstanding and discard counts and the issue credit.
    always_comb begin
        outst_n = outst + OW'(acc) - OW'(bus_rvalid);
        if (apply)
            discard_n = outst_n;
        else if (bus_rvalid && discard != '0)
            discard_n = discard - 1'b1;
        else
            discard_n = discard;
        good_n     = apply ? '0 : outst_n - discard_n;
        credit_sum = {1'b0, good_n} + (OW+1)'(buf_cnt_nxt);
        room       = (credit_sum < (OW+1)'(DEPTH)) && (outst_n < OW'(OUT_MAX));
    end

    // Fetch counter, request strobe and redirect state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppc     <= START_ADDR;
            req_q   <= 1'b0;
            redir_q <= 1'b0;
            tgt_q   <= '0;
            outst   <= '0;
            discard <= '0;
        end else begin
            if (apply)    ppc <= apply_addr;
            else if (acc) ppc <= ppc + PF_AW'(4);
            req_q   <= stuck | room;
            redir_q <= flush & stuck;
            if (br_taken) tgt_q <= br_target;
            outst   <= outst_n;
            discard <= discard_n;
        end
    end

    assign bus_addr = ppc;
    assign bus_read = req_q;

    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bus_addr == START_ADDR));  // R1
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && !bus_waitreq && !flush) |=> (bus_addr == $past(bus_addr) + PF_AW'(4)));  // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && bus_waitreq) |=> (bus_read && $stable(bus_addr)));  // R3
    AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && !(bus_read && bus_waitreq)) |=> (bus_addr[PF_AW-1:2] == $past(br_target[PF_AW-1:2])));  // R7
    AST_STUCK_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && bus_read && bus_waitreq) |=> (bus_read && $stable(bus_addr)));  // R9
    AST_DISCARD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        discard <= outst);  // R7
endmodule

// File: rtl/instr_prefetch.sv
// Instruction prefetch unit top: joins the bus controller and the
// instruction buffer, tracks the fetch address of the next response and
// offers words to decode with a same-cycle bypass when the buffer is empty.
// Assumes responses return in issue order.
module instr_prefetch
    import pf_pkg::*;
#(
    parameter int unsigned DEPTH      = 4,
    parameter logic [31:0] START_ADDR = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [PF_AW-1:0] bus_addr,
    output logic             bus_read,
    input  logic             bus_waitreq,
    input  logic [PF_DW-1:0] bus_rdata,
    input  logic             bus_rvalid,
    input  logic             br_taken,
    input  logic [PF_AW-1:0] br_target,
    output logic             dec_valid,
    output logic [PF_DW-1:0] dec_instr,
    output logic [PF_AW-1:0] dec_addr,
    input  logic             dec_stall
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic             flush, stale, apply;
    logic [PF_AW-1:0] apply_addr;
    logic [PF_AW-1:0] ret_pc;
    logic [CW-1:0]    buf_cnt, buf_cnt_nxt;
    pf_entry_t        head, wr_entry;
    logic             good_rsp, buf_empty, bypass, push, pop;

    pf_bus_ctl #(.DEPTH(DEPTH), .START_ADDR(START_ADDR)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_waitreq (bus_waitreq),
        .bus_rvalid  (bus_rvalid),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .buf_cnt_nxt (buf_cnt_nxt),
        .bus_addr    (bus_addr),
        .bus_read    (bus_read),
        .flush       (flush),
        .stale       (stale),
        .apply       (apply),
        .apply_addr  (apply_addr)
    );

    // Buffer control: bypass when empty and ready, otherwise park the word.
    always_comb begin
        good_rsp    = bus_rvalid & ~stale;
        buf_empty   = (buf_cnt == '0);
        bypass      = good_rsp & buf_empty & ~dec_stall;
        push        = good_rsp & ~bypass;
        pop         = ~buf_empty & ~dec_stall & ~flush;
        buf_cnt_nxt = flush ? '0 : buf_cnt + CW'(push) - CW'(pop);
        wr_entry    = '{addr: ret_pc, instr: bus_rdata};
    end

    pf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push    (push),
        .wr_data (wr_entry),
        .pop     (pop),
        .head    (head),
        .count   (buf_cnt)
    );

    // Fetch address of the next accepted response.
    always_ff @(posedge clk) begin
        if (!rst_n)        ret_pc <= START_ADDR;
        else if (apply)    ret_pc <= apply_addr;
        else if (good_rsp) ret_pc <= ret_pc + PF_AW'(4);
    end

    // Decode-side output selection.
    always_comb begin
        dec_valid = ~flush & (~buf_empty | good_rsp);
        dec_instr = buf_empty ? bus_rdata : head.instr;
        dec_addr  = buf_empty ? ret_pc    : head.addr;
    end

    AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_stall && !br_taken) |=>
        (br_taken || (dec_valid && $stable(dec_addr) && $stable(dec_instr))));  // R5
endmodule

// File: tb/instr_prefetch_bench.sv
module instr_prefetch_bench;
    localparam int unsigned DEPTH = 4;
    localparam logic [31:0] START = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr;
    logic        bus_read;
    logic        bus_waitreq = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        bus_rvalid = 1'b0;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic        dec_valid;
    logic [31:0] dec_instr;
    logic [31:0] dec_addr;
    logic        dec_stall = 1'b0;

    always #4 clk = ~clk;

    instr_prefetch #(.DEPTH(DEPTH), .START_ADDR(START)) u_instr_prefetch (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_read(bus_read),
        .bus_waitreq(bus_waitreq), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .br_taken(br_taken), .br_target(br_target), .dec_valid(dec_valid),
        .dec_instr(dec_instr), .dec_addr(dec_addr), .dec_stall(dec_stall)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // memory model queue
    logic [31:0] q_addr [256];
    int          q_due  [256];
    int          qh, qt, last_due;
    int          p_wait, lat_min, lat_max;
    bit          force_wait, stall_v;

    // expected-flow model
    logic [31:0] exp_rd, exp_pc, pend_tgt, prev_addr;
    bit          redir_pend, prev_stuck, first_acc, after_br_rd, after_br_dl;
    int          accepts;
    bit          obs_read, obs_valid;
    logic [31:0] obs_addr;

    function automatic logic [31:0] data_of(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input bit br, input logic [31:0] tgt);
        int lat, due;
        string tag;
        @(negedge clk);
        bus_waitreq = force_wait ? 1'b1 : (int'($urandom_range(0, 99)) < p_wait);
        if (qh != qt && q_due[qh % 256] <= cyc) begin
            bus_rvalid = 1'b1;
            bus_rdata  = data_of(q_addr[qh % 256]);
            qh++;
        end else begin
            bus_rvalid = 1'b0;
            bus_rdata  = $urandom;
        end
        br_taken  = br;
        br_target = tgt;
        dec_stall = stall_v;
        #1;
        obs_read  = bus_read;
        obs_valid = dec_valid;
        obs_addr  = dec_addr;
        if (rst_n) begin
            if (prev_stuck)
                chk(bus_read && bus_addr == prev_addr, "R3", bus_addr, prev_addr);
            if (bus_read && !bus_waitreq) begin
                tag = first_acc ? "R1" : (redir_pend ? "R9" : (after_br_rd ? "R7" : "R2"));
                chk(bus_addr == exp_rd, tag, bus_addr, exp_rd);
                first_acc   = 1'b0;
                after_br_rd = 1'b0;
                if (redir_pend) begin
                    exp_rd      = pend_tgt;
                    redir_pend  = 1'b0;
                    after_br_rd = 1'b1;
                end else begin
                    exp_rd = exp_rd + 32'd4;
                end
                lat = int'($urandom_range(lat_min, lat_max));
                due = cyc + lat;
                if (due <= last_due) due = last_due + 1;
                last_due = due;
                q_addr[qt % 256] = bus_addr;
                q_due[qt % 256]  = due;
                qt++;
                accepts++;
            end
            if (dec_valid && !dec_stall && !br) begin
                tag = after_br_dl ? "R7" : "R5";
                chk(dec_addr == exp_pc, tag, dec_addr, exp_pc);
                chk(dec_instr == data_of(exp_pc), tag, dec_instr, data_of(exp_pc));
                exp_pc      = exp_pc + 32'd4;
                after_br_dl = 1'b0;
            end
            if (br) begin
                chk(!dec_valid, "R8", {31'd0, dec_valid}, 32'd0);
                exp_pc      = {tgt[31:2], 2'b00};
                after_br_dl = 1'b1;
                if (bus_read && bus_waitreq) begin
                    redir_pend = 1'b1;
                    pend_tgt   = {tgt[31:2], 2'b00};
                end else begin
                    exp_rd      = {tgt[31:2], 2'b00};
                    after_br_rd = 1'b1;
                end
            end
        end
        prev_stuck = rst_n && bus_read && bus_waitreq;
        prev_addr  = bus_addr;
        cyc++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        qh = 0; qt = 0; last_due = 0;
        exp_rd = START; exp_pc = START;
        redir_pend = 0; prev_stuck = 0; first_acc = 1;
        after_br_rd = 0; after_br_dl = 0; accepts = 0;
        force_wait = 0;
        for (int i = 0; i < 3; i++) begin
            step(1'b0, '0);
            chk(!obs_read, "R1", {31'd0, obs_read}, 32'd0);
            chk(!obs_valid, "R1", {31'd0, obs_valid}, 32'd0);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        int unsigned seed;
        seed = $urandom(32'd2024);
        // R6 bypass with empty buffer
        p_wait = 0; lat_min = 3; lat_max = 3; stall_v = 0;
        do_reset();
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            step(1'b0, '0);
            if (bus_rvalid && !seen) begin
                seen = 1;
                chk(obs_valid && obs_addr == START, "R6", obs_addr, START);
            end
        end
        chk(seen, "R6", {31'd0, seen}, 32'd1);

        // R4 stall from reset fills exactly DEPTH
        stall_v = 1; lat_min = 2; lat_max = 2;
        do_reset();
        for (int i = 0; i < 20; i++) step(1'b0, '0);
        chk(accepts == DEPTH, "R4", accepts, DEPTH);
        for (int i = 0; i < 3; i++) begin
            step(1'b0, '0);
            chk(obs_valid && obs_addr == START, "R5", obs_addr, START);
        end
        stall_v = 0;
        for (int i = 0; i < 30; i++) step(1'b0, '0);

        // R7 R8 redirect with unaligned target
        lat_min = 2; lat_max = 4;
        for (int i = 0; i < 6; i++) step(1'b0, '0);
        step(1'b1, 32'h0000_2007);
        for (int i = 0; i < 20; i++) step(1'b0, '0);

        // R9 redirect while a read is held by wait-request
        for (int i = 0; i < 10 && !obs_read; i++) step(1'b0, '0);
        force_wait = 1;
        step(1'b0, '0);
        step(1'b0, '0);
        step(1'b1, 32'h0000_3000);
        step(1'b0, '0);
        step(1'b0, '0);
        force_wait = 0;
        for (int i = 0; i < 20; i++) step(1'b0, '0);

        // random traffic
        p_wait = 25; lat_min = 1; lat_max = 6;
        for (int i = 0; i < 4000; i++) begin
            stall_v = (int'($urandom_range(0, 99)) < 30);
            if (int'($urandom_range(0, 99)) < 3)
                step(1'b1, $urandom & 32'h0000_FFFF);
            else
                step(1'b0, '0);
        end
        stall_v = 0; p_wait = 0;
        for (int i = 0; i < 30; i++) step(1'b0, '0);
        chk(n_tests > 100, "R5", n_tests, 100);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule